// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block watches load-exclusive and store-exclusive requests from one requester on a shared memory bus. It also watches the accesses that the other bus agents make, through a snoop port. A load-exclusive opens a reservation on the aligned granule that holds its address. The granule is a power-of-two number of bytes and is set by a parameter. Any later access that lands anywhere inside that granule closes the reservation. This includes an ordinary access by the same requester to a neighbouring field. A store-exclusive is answered with pass or fail. The write is only allowed through when the answer is pass.

An exclusive request whose address is not aligned to its access size raises a fault and leaves the monitor untouched. A parameter selects local-only behaviour. In that mode, snoop traffic and the requester's own ordinary accesses are ignored, and only a newer load-exclusive can change the reservation. The granule parameter covers 8 bytes up to 2048 bytes (512 words). The default is 32 bytes, one cache line.

Top module: `excl_resv_monitor`

## Requirements
- R1: A synchronous active-high reset clears the reservation and drives all four result outputs low; a store-exclusive after reset fails.
- R2: After an aligned load-exclusive, an aligned store-exclusive to any address in the same granule (base = address with its low log2(GRANULE_BYTES) bits cleared) passes if nothing broke the reservation in between. One cycle after the store request, st_done=1, st_fail=0 and wr_allow=1.
- R3: A store-exclusive with no valid reservation, or with a granule base different from the reserved one, fails. One cycle later, st_done=1, st_fail=1 and wr_allow=0.
- R4: Every aligned store-exclusive clears the reservation, whether it passes or fails.
- R5: In global mode (LOCAL_ONLY=0), a snoop access (snp_valid=1) whose address lies inside the reserved granule clears the reservation; a snoop outside it has no effect.
- R6: In global mode, an ordinary load or store from the requester inside the reserved granule clears the reservation, so the next store-exclusive fails.
- R7: A load-exclusive replaces any existing reservation with the granule base of its own address.
- R8: A load-exclusive or store-exclusive with an illegal size, or with an address not aligned to its size, raises excl_fault one cycle later. It gives no store status and leaves the reservation unchanged. Ordinary accesses never fault. Legal size values are 1, 2, 4 and 8 bytes.
- R9: In local-only mode (LOCAL_ONLY=1), snoop accesses and ordinary accesses from the requester do not affect the reservation.
- R10: In global mode, a snoop hit in the same cycle as a store-exclusive makes that store fail. A load-exclusive in the same cycle as a snoop to its granule still leaves a valid reservation.
- R11: The request kind is encoded as 0 = ordinary load, 1 = ordinary store, 2 = load-exclusive, 3 = store-exclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester access valid this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| snp_valid | input | 1 | Access by another bus agent observed |
| snp_addr | input | ADDR_W | Byte address of the observed access |
| st_done | output | 1 | Store-exclusive result valid |
| st_fail | output | 1 | Store-exclusive status: 0 success, 1 failure |
| wr_allow | output | 1 | Store-exclusive write may proceed |
| excl_fault | output | 1 | Alignment fault on an exclusive request |

## Verification
Every result of this block is registered once. The store status, the write permission and the alignment fault all belong to the request presented one edge earlier. A reservation change shows up only in the outcome of a later store-exclusive. For each cycle of stimulus, the driver queues the expected result vector, even when that vector is all zeros. The monitor pops it at the falling edge after the next rising edge, so each check samples exactly one register stage after its cause. Two instances, one global with a 32-byte granule and one local-only with a 2048-byte granule, receive the same stimulus. Each has its own expected values.

// File: rtl/excl_pkg.sv
package excl_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_LDEX  = 2'd2,
      ACC_STEX  = 2'd3
   } acc_kind_e;

   localparam int unsigned MAX_ACC_BYTES = 8;
   localparam int unsigned MIN_GRANULE   = 8;
   localparam int unsigned MAX_GRANULE   = 2048;

   function automatic logic is_exclusive(input logic [1:0] kind);
      return (kind == ACC_LDEX) || (kind == ACC_STEX);
   endfunction

   function automatic logic is_plain(input logic [1:0] kind);
      return (kind == ACC_LOAD) || (kind == ACC_STORE);
   endfunction

endpackage

// File: rtl/excl_align_check.sv
module excl_align_check #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        size,
   output logic              bad
);
   logic       legal;
   logic [3:0] mask;

   always_comb begin
      legal = (size == 4'd1) || (size == 4'd2) || (size == 4'd4) || (size == 4'd8);
      mask  = size - 4'd1;
      bad   = !legal || ((mask & {1'b0, addr[2:0]}) != 4'd0);
   end
endmodule

// File: rtl/excl_granule_tag.sv
module excl_granule_tag #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned GRANULE_BYTES = 32,
   localparam int unsigned OFFS         = $clog2(GRANULE_BYTES),
   localparam int unsigned TAG_W        = ADDR_W - OFFS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag
);
   assign tag = addr[ADDR_W-1:OFFS];
endmodule

// File: rtl/excl_break_detect.sv
module excl_break_detect #(
   parameter int unsigned TAG_W      = 27,
   parameter bit          LOCAL_ONLY = 1'b0
) (
   input  logic             resv_valid,
   input  logic [TAG_W-1:0] resv_tag,
   input  logic             own_plain,
   input  logic [TAG_W-1:0] own_tag,
   input  logic             snp_valid,
   input  logic [TAG_W-1:0] snp_tag,
   output logic             brk
);
   logic own_hit;
   logic snp_hit;

   assign own_hit = own_plain && (own_tag == resv_tag);
   assign snp_hit = snp_valid && (snp_tag == resv_tag);

   generate
      if (LOCAL_ONLY) begin : g_local
         assign brk = resv_valid && 1'b0 && (own_hit || snp_hit);
      end else begin : g_global
         assign brk = resv_valid && (own_hit || snp_hit);
      end
   endgenerate
endmodule

// File: rtl/excl_resv_state.sv
module excl_resv_state #(
   parameter int unsigned TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set,
   input  logic [TAG_W-1:0] set_tag,
   input  logic             clr,
   output logic             valid,
   output logic [TAG_W-1:0] tag
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         tag   <= '0;
      end else if (set) begin
         valid <= 1'b1;
         tag   <= set_tag;
      end else if (clr) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor
   import excl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned GRANULE_BYTES = 32,
   parameter bit          LOCAL_ONLY    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_size,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              st_done,
   output logic              st_fail,
   output logic              wr_allow,
   output logic              excl_fault
);
   localparam int unsigned OFFS  = $clog2(GRANULE_BYTES);
   localparam int unsigned TAG_W = ADDR_W - OFFS;

   generate
      if ((GRANULE_BYTES & (GRANULE_BYTES - 1)) != 0) begin : g_chk_pow2
         $error("GRANULE_BYTES must be a power of two");
      end
      if (GRANULE_BYTES < MIN_GRANULE || GRANULE_BYTES > MAX_GRANULE) begin : g_chk_range
         $error("GRANULE_BYTES must lie between 8 and 2048");
      end
      if (ADDR_W <= OFFS || ADDR_W < 3) begin : g_chk_addr
         $error("ADDR_W too narrow for the granule");
      end
   endgenerate

   logic [TAG_W-1:0] req_tag;
   logic [TAG_W-1:0] snp_tag;
   logic [TAG_W-1:0] resv_tag;
   logic             resv_valid;
   logic             misaligned;
   logic             brk;
   logic             ldex_ok;
   logic             stex_ok;
   logic             own_plain;
   logic             fault_d;
   logic             pass_d;

   excl_granule_tag #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) u_req_tag (
      .addr(req_addr), .tag(req_tag)
   );
   excl_granule_tag #(.ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES)) u_snp_tag (
      .addr(snp_addr), .tag(snp_tag)
   );

   excl_align_check #(.ADDR_W(ADDR_W)) u_align (
      .addr(req_addr), .size(req_size), .bad(misaligned)
   );

   always_comb begin
      own_plain = req_valid && is_plain(req_kind);
      fault_d   = req_valid && is_exclusive(req_kind) && misaligned;
      ldex_ok   = req_valid && (req_kind == ACC_LDEX) && !misaligned;
      stex_ok   = req_valid && (req_kind == ACC_STEX) && !misaligned;
   end

   excl_break_detect #(.TAG_W(TAG_W), .LOCAL_ONLY(LOCAL_ONLY)) u_brk (
      .resv_valid(resv_valid),
      .resv_tag  (resv_tag),
      .own_plain (own_plain),
      .own_tag   (req_tag),
      .snp_valid (snp_valid),
      .snp_tag   (snp_tag),
      .brk       (brk)
   );

   assign pass_d = stex_ok && resv_valid && (resv_tag == req_tag) && !brk;

   excl_resv_state #(.TAG_W(TAG_W)) u_state (
      .clk    (clk),
      .rst    (rst),
      .set    (ldex_ok),
      .set_tag(req_tag),
      .clr    (stex_ok || brk),
      .valid  (resv_valid),
      .tag    (resv_tag)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_done    <= 1'b0;
         st_fail    <= 1'b0;
         wr_allow   <= 1'b0;
         excl_fault <= 1'b0;
      end else begin
         st_done    <= stex_ok;
         st_fail    <= stex_ok && !pass_d;
         wr_allow   <= pass_d;
         excl_fault <= fault_d;
      end
   end
endmodule

// File: rtl/excl_resv_checker.sv
module excl_resv_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              resv_valid,
   input logic              st_done,
   input logic              st_fail,
   input logic              wr_allow,
   input logic              excl_fault
);
   assert_wr_only_on_pass_R2: assert property (@(posedge clk) disable iff (rst)
      wr_allow |-> (st_done && !st_fail));

   assert_status_follows_stex_R2: assert property (@(posedge clk) disable iff (rst)
      st_done |-> $past(req_valid && req_kind == 2'd3));

   assert_pass_needs_resv_R3: assert property (@(posedge clk) disable iff (rst)
      (st_done && !st_fail) |-> $past(resv_valid));

   assert_stex_clears_R4: assert property (@(posedge clk) disable iff (rst)
      st_done |-> !resv_valid);

   assert_fault_from_excl_R8: assert property (@(posedge clk) disable iff (rst)
      excl_fault |-> $past(req_valid && req_kind[1]));

   assert_fault_no_status_R8: assert property (@(posedge clk) disable iff (rst)
      excl_fault |-> !st_done);

   assert_fault_keeps_resv_R8: assert property (@(posedge clk) disable iff (rst)
      excl_fault |-> $stable(resv_valid));

   assert_addr_known_R11: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> !$isunknown({req_kind, req_addr}));
endmodule

bind excl_resv_monitor excl_resv_checker #(.ADDR_W(ADDR_W)) u_excl_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .req_addr  (req_addr),
   .resv_valid(resv_valid),
   .st_done   (st_done),
   .st_fail   (st_fail),
   .wr_allow  (wr_allow),
   .excl_fault(excl_fault)
);

// File: tb/test_excl_resv_monitor.sv
`timescale 1ns/1ps
module test_excl_resv_monitor;
   localparam int unsigned AW = 32;
   localparam logic [3:0] PASS  = 4'b1010;
   localparam logic [3:0] FAIL_ = 4'b1100;
   localparam logic [3:0] FLT   = 4'b0001;
   localparam logic [3:0] NONE  = 4'b0000;
   localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_LDX = 2'd2, K_STX = 2'd3;

   typedef struct {
      logic [3:0] g;
      logic [3:0] l;
      string      tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0]    req_size = 4'd4;
   logic          snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic g_done, g_fail, g_wr, g_flt;
   logic l_done, l_fail, l_wr, l_flt;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   excl_resv_monitor #(.ADDR_W(AW), .GRANULE_BYTES(32), .LOCAL_ONLY(1'b0)) i_excl_resv_monitor (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_size(req_size), .snp_valid(snp_valid),
      .snp_addr(snp_addr), .st_done(g_done), .st_fail(g_fail),
      .wr_allow(g_wr), .excl_fault(g_flt)
   );

   excl_resv_monitor #(.ADDR_W(AW), .GRANULE_BYTES(2048), .LOCAL_ONLY(1'b1)) i_local (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_size(req_size), .snp_valid(snp_valid),
      .snp_addr(snp_addr), .st_done(l_done), .st_fail(l_fail),
      .wr_allow(l_wr), .excl_fault(l_flt)
   );

   task automatic compare(input string tag, input string which,
                          input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s): {done,fail,wr,fault} actual %b expected %b",
                  tag, which, act, exp);
      end
   endtask

   // monitor: one result per driven cycle, one register stage later
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         compare(e.tag, "global", {g_done, g_fail, g_wr, g_flt}, e.g);
         compare(e.tag, "local",  {l_done, l_fail, l_wr, l_flt}, e.l);
      end
   end

   task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [3:0] sz, input logic sv, input logic [AW-1:0] sa,
                       input logic [3:0] eg, input logic [3:0] el, input string tag);
      exp_t e;
      @(negedge clk);
      #1;
      req_valid = v; req_kind = k; req_addr = a; req_size = sz;
      snp_valid = sv; snp_addr = sa;
      e.g = eg; e.l = el; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle();
      step(1'b0, K_LD, '0, 4'd4, 1'b0, '0, NONE, NONE, "idle");
   endtask

   task automatic do_reset();
      @(negedge clk);
      @(negedge clk);
      #1;
      req_valid = 1'b0; snp_valid = 1'b0; rst = 1'b1;
      @(posedge clk);
      #1;
      compare("R1 reset", "global", {g_done, g_fail, g_wr, g_flt}, NONE);
      compare("R1 reset", "local",  {l_done, l_fail, l_wr, l_flt}, NONE);
      @(negedge clk);
      #1;
      rst = 1'b0;
   endtask

   initial begin
      #(4 * 20000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R1/R3: store-exclusive straight after reset fails
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, FAIL_, "R1 R3 stex without reservation");
      // R2: pass within same granule
      step(1, K_LDX, 32'h1004, 4, 0, 0, NONE, NONE, "R2 ldex");
      step(1, K_STX, 32'h101C, 4, 0, 0, PASS, PASS, "R2 stex same granule");
      // R4: reservation consumed
      step(1, K_STX, 32'h101C, 4, 0, 0, FAIL_, FAIL_, "R4 second stex");
      // R3: different granule (global 32 B), same granule for 2 KB local
      step(1, K_LDX, 32'h1000, 8, 0, 0, NONE, NONE, "R3 ldex");
      step(1, K_STX, 32'h1020, 4, 0, 0, FAIL_, PASS, "R3 stex other granule");
      // R5/R9: snoop inside granule
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R5 ldex");
      step(0, K_LD, 0, 4, 1, 32'h1010, NONE, NONE, "R5 snoop hit");
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, PASS, "R5 R9 stex after snoop hit");
      // R5: snoop outside 32 B granule has no effect
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R5 ldex");
      step(0, K_LD, 0, 4, 1, 32'h1040, NONE, NONE, "R5 snoop miss");
      step(1, K_STX, 32'h1008, 4, 0, 0, PASS, PASS, "R5 stex after snoop miss");
      // R6/R9: own ordinary store to neighbour field
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R6 ldex");
      step(1, K_ST, 32'h1008, 4, 0, 0, NONE, NONE, "R6 plain store");
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, PASS, "R6 R9 stex after own store");
      // R7: replacement
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R7 ldex first");
      step(1, K_LDX, 32'h3000, 4, 0, 0, NONE, NONE, "R7 ldex second");
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, FAIL_, "R7 stex old granule");
      // R8: misaligned ldex leaves reservation intact
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R8 ldex");
      step(1, K_LDX, 32'h1002, 4, 0, 0, FLT, FLT, "R8 misaligned ldex");
      step(1, K_STX, 32'h1006, 2, 0, 0, PASS, PASS, "R8 stex after fault");
      // R8: misaligned stex gives fault, no status, no state change
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R8 ldex");
      step(1, K_STX, 32'h1001, 2, 0, 0, FLT, FLT, "R8 misaligned stex");
      step(1, K_STX, 32'h1000, 4, 0, 0, PASS, PASS, "R8 stex after faulted stex");
      // R8: illegal size
      step(1, K_LDX, 32'h1000, 3, 0, 0, FLT, FLT, "R8 illegal size ldex");
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, FAIL_, "R8 stex no reservation");
      // R8/R11: misaligned ordinary load never faults
      step(1, K_LD, 32'h1001, 4, 0, 0, NONE, NONE, "R8 R11 plain misaligned");
      // R10: same-cycle snoop hit with stex
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R10 ldex");
      step(1, K_STX, 32'h1000, 4, 1, 32'h1004, FAIL_, PASS, "R10 stex with snoop hit");
      // R10: ldex wins over same-cycle snoop
      step(1, K_LDX, 32'h1000, 4, 1, 32'h1000, NONE, NONE, "R10 ldex with snoop");
      step(1, K_STX, 32'h1000, 4, 0, 0, PASS, PASS, "R10 stex after ldex+snoop");
      // R1: reset mid-run drops reservation
      step(1, K_LDX, 32'h1000, 4, 0, 0, NONE, NONE, "R1 ldex");
      idle();
      do_reset();
      step(1, K_STX, 32'h1000, 4, 0, 0, FAIL_, FAIL_, "R1 stex after reset");
      idle();
      idle();
      @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule